// File: doc/BRIEF.md
# Two-Wire Memory Slave Interface

This block is the serial front end of a small byte-addressed memory. It watches an oversampled two-wire bus (SCL and SDA), recognises START, STOP and repeated START, and accepts a device byte made of a fixed four-bit code, three strap bits and a read/write flag. When the device byte matches, it acknowledges and then moves bytes between the bus and a memory back end through single-cycle read and write strobes.

A write carries a memory address byte followed by any number of data bytes; each data byte becomes one write strobe at the internal pointer, which then steps by one. A read streams bytes from the pointer for as long as the master acknowledges. A random read is a write that carries only the address byte, followed by a repeated START and a read device byte. The pointer lives across transactions and wraps from the top of the 256-byte space to zero. While the back end reports an internal write in progress, the device byte is not acknowledged, so the master can poll until the acknowledge returns.

The bus pins are sampled with a system clock at least 16 times faster than SCL. SDA is driven only as an open-drain pull-down enable.

Top module: `twoWireMemSlave`

## Requirements
- R1: A device byte whose upper seven bits equal 1010 followed by `strapAddr[2:0]` (sent MSB first; bit 0 = 1 selects read) is acknowledged by pulling SDA low during the ninth clock.
- R2: A device byte that does not match is not acknowledged; the block then drives nothing and issues no strobe until the next START, and every later byte of that transfer is ignored.
- R3: In a write, the byte after the device byte loads the pointer; each following data byte is acknowledged and produces one write strobe at the pointer, after which the pointer steps by one (page write); read and write strobes never coincide.
- R4: The pointer holds the last accessed address plus one, wraps from FFh to 00h, and keeps its value between transactions, so a read started without an address byte begins at it.
- R5: After a write holding only an address byte, a repeated START and a read device byte return data starting at that address.
- R6: In a read the block sends a further byte each time the master acknowledges; after a master not-acknowledge it releases SDA and stays released.
- R7: While `memBusy` is high the device byte is not acknowledged and no strobe is issued; once it falls the same device byte is acknowledged again.
- R8: The SDA pull-down changes only while SCL is low; an SDA fall while SCL is high is a START and an SDA rise while SCL is high is a STOP.
- R9: A START arriving in the middle of a byte abandons it and restarts device-byte reception.
- R10: After reset SDA is released and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Bus clock level |
| sdaIn | input | 1 | Bus data level (wired-AND of all drivers) |
| strapAddr | input | 3 | Strap bits completing the device address |
| sdaDrvLow | output | 1 | 1 = pull SDA low |
| memBusy | input | 1 | Back end is performing an internal write |
| memWrEn | output | 1 | One-cycle write strobe |
| memRdEn | output | 1 | One-cycle read strobe; data expected on memRdData from the next cycle |
| memAddr | output | 8 | Current pointer, address for both strobes |
| memWrData | output | 8 | Byte to write |
| memRdData | input | 8 | Byte from back end, held until the next read strobe |

## Verification
The assertions take for granted that each SCL phase lasts well beyond the synchroniser and edge-detect delay, that the master moves SDA only in the middle of the SCL low phase, and that `memBusy` rises only after the STOP that closes a write and never during a transfer. The bench master holds each SCL phase for ten clocks and changes SDA five clocks into the low phase, and its back-end model raises the busy flag only on a STOP that followed at least one write strobe. The back-end model also keeps read data stable from one read strobe to the next, which the transmit path relies on.

// File: rtl/twsPkg.sv
package twsPkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_ADDR, S_WDAT, S_ACK, S_TX, S_MACK
  } twsState_t;

  // Bus events found on the synchronised pins
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
  } busEv_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic ptrLoad;
    logic ptrInc;
    logic txLoad;
    logic txShift;
  } dpCtl_t;
endpackage

// File: rtl/twsDatapath.sv
module twsDatapath
  import twsPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtl_t            ctl,
  input  logic [BYTE_W-1:0] memRdData,
  output busEv_t            ev,
  output logic              sdaBit,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txBit,
  output logic [BYTE_W-1:0] ptr
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclNow, sdaNow, sclPrev, sdaPrev;
  logic [BYTE_W-1:0] txReg;

  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_comb begin
    ev.sclRise  = sclNow & ~sclPrev;
    ev.sclFall  = ~sclNow & sclPrev;
    ev.startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
    ev.stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte <= '0;
      txReg  <= '1;
      ptr    <= '0;
    end else begin
      if (ev.sclRise) rxByte <= {rxByte[BYTE_W-2:0], sdaNow};
      if (ctl.txLoad)       txReg <= memRdData;
      else if (ctl.txShift) txReg <= {txReg[BYTE_W-2:0], 1'b1};
      if (ctl.ptrLoad)      ptr <= rxByte;
      else if (ctl.ptrInc)  ptr <= ptr + 1'b1;
    end
  end

  assign sdaBit = sdaNow;
  assign txBit  = txReg[BYTE_W-1];
endmodule

// File: rtl/twsControl.sv
module twsControl
  import twsPkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEv_t            ev,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txBit,
  input  logic [2:0]        strapAddr,
  input  logic              memBusy,
  output dpCtl_t            ctl,
  output logic              sdaDrvLow,
  output logic              memWrEn,
  output logic              memRdEn
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  twsState_t state, stN, afterAck, afterAckN;
  logic [CNT_W-1:0] bitCnt, cntN;
  logic byteDone, doneN, mAck, mAckN;
  logic devHit;

  assign devHit = (rxByte[BYTE_W-1:1] == {DEV_CODE, strapAddr});

  always_comb begin
    stN       = state;
    afterAckN = afterAck;
    cntN      = bitCnt;
    doneN     = byteDone;
    mAckN     = mAck;
    ctl       = '0;
    memWrEn   = 1'b0;
    memRdEn   = 1'b0;
    if (ev.startDet) begin
      stN   = S_DEV;
      cntN  = '0;
      doneN = 1'b0;
    end else if (ev.stopDet) begin
      stN = S_IDLE;
    end else begin
      case (state)
        S_DEV, S_ADDR, S_WDAT: begin
          if (ev.sclRise && !byteDone) begin
            cntN = bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) doneN = 1'b1;
          end else if (ev.sclFall && byteDone) begin
            doneN = 1'b0;
            cntN  = '0;
            if (state == S_DEV) begin
              if (devHit && !memBusy) begin
                stN = S_ACK;
                if (rxByte[0]) begin
                  afterAckN  = S_TX;
                  memRdEn    = 1'b1;
                  ctl.ptrInc = 1'b1;
                end else begin
                  afterAckN = S_ADDR;
                end
              end else begin
                stN = S_IDLE;
              end
            end else if (state == S_ADDR) begin
              stN         = S_ACK;
              afterAckN   = S_WDAT;
              ctl.ptrLoad = 1'b1;
            end else begin
              stN        = S_ACK;
              afterAckN  = S_WDAT;
              memWrEn    = 1'b1;
              ctl.ptrInc = 1'b1;
            end
          end
        end
        S_ACK: if (ev.sclFall) begin
          stN  = afterAck;
          cntN = '0;
          if (afterAck == S_TX) ctl.txLoad = 1'b1;
        end
        S_TX: if (ev.sclFall) begin
          if (bitCnt == LAST_BIT) begin
            stN  = S_MACK;
            cntN = '0;
          end else begin
            ctl.txShift = 1'b1;
            cntN        = bitCnt + 1'b1;
          end
        end
        S_MACK: begin
          if (ev.sclRise) begin
            mAckN = ~sdaBit;
            if (!sdaBit) begin
              memRdEn    = 1'b1;
              ctl.ptrInc = 1'b1;
            end
          end else if (ev.sclFall) begin
            if (mAck) begin
              stN        = S_TX;
              ctl.txLoad = 1'b1;
            end else begin
              stN = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      afterAck <= S_IDLE;
      bitCnt   <= '0;
      byteDone <= 1'b0;
      mAck     <= 1'b0;
    end else begin
      state    <= stN;
      afterAck <= afterAckN;
      bitCnt   <= cntN;
      byteDone <= doneN;
      mAck     <= mAckN;
    end
  end

  assign sdaDrvLow = (state == S_ACK) | ((state == S_TX) & ~txBit);
endmodule

// File: rtl/twoWireMemSlave.sv
module twoWireMemSlave
  import twsPkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        strapAddr,
  output logic              sdaDrvLow,
  input  logic              memBusy,
  output logic              memWrEn,
  output logic              memRdEn,
  output logic [BYTE_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWrData,
  input  logic [BYTE_W-1:0] memRdData
);
  busEv_t ev;
  dpCtl_t ctl;
  logic sdaBit, txBit;
  logic [BYTE_W-1:0] rxByte;

  twsDatapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .memRdData(memRdData), .ev(ev), .sdaBit(sdaBit), .rxByte(rxByte),
    .txBit(txBit), .ptr(memAddr)
  );

  twsControl #(.DEV_CODE(DEV_CODE)) ctl_i (
    .clk(clk), .rstN(rstN), .ev(ev), .sdaBit(sdaBit), .rxByte(rxByte),
    .txBit(txBit), .strapAddr(strapAddr), .memBusy(memBusy), .ctl(ctl),
    .sdaDrvLow(sdaDrvLow), .memWrEn(memWrEn), .memRdEn(memRdEn)
  );

  assign memWrData = rxByte;
endmodule

// File: rtl/twsChecker.sv
module twsChecker (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaDrvLow,
  input logic       memBusy,
  input logic       memWrEn,
  input logic       memRdEn,
  input logic [7:0] memAddr
);
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrEn && memRdEn));

  assert_wr_ptr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> (memAddr == $past(memAddr) + 8'd1));

  assert_rd_ptr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (memAddr == $past(memAddr) + 8'd1));

  assert_drive_scl_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDrvLow) |-> !sclIn);

  assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    memBusy |-> (!memWrEn && !memRdEn));
endmodule

bind twoWireMemSlave twsChecker chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDrvLow(sdaDrvLow),
  .memBusy(memBusy), .memWrEn(memWrEn), .memRdEn(memRdEn), .memAddr(memAddr)
);

// File: tb/twoWireMemSlave_tb_top.sv
`timescale 1ns/1ps
module twoWireMemSlave_tb_top;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaBus, sdaDrvLow, memBusy, memWrEn, memRdEn;
  logic [7:0] memAddr, memWrData, memRdData;

  always #10 clk = ~clk;
  assign sdaBus = sdaM & ~sdaDrvLow;

  twoWireMemSlave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .strapAddr(STRAP),
    .sdaDrvLow(sdaDrvLow), .memBusy(memBusy), .memWrEn(memWrEn), .memRdEn(memRdEn),
    .memAddr(memAddr), .memWrData(memWrData), .memRdData(memRdData)
  );

  // Expected model, owned by the stimulus process
  bit [7:0]  expMem [256];
  bit [15:0] expWr [64];
  int expCnt = 0;
  bit [7:0] modelPtr = 8'h00;
  int nChecks = 0, nFails = 0;
  bit timedOut = 1'b0;

  // Back-end model and per-clock comparison, owned by this process
  bit [7:0] mem [256];
  int wrIdx = 0, busyCnt = 0, cChecks = 0, cFails = 0;
  bit sawWrite = 1'b0, drvPrev = 1'b0, sdaPrev = 1'b1;
  logic [7:0] rdReg = 8'h00;
  assign memRdData = rdReg;
  assign memBusy = (busyCnt != 0);

  always @(posedge clk) begin
    if (rstN) begin
      if (sdaDrvLow != drvPrev) begin
        cChecks++;
        if (sclM) begin
          cFails++;
          $display("FAIL R8 drive changed with SCL high: actual=%0d expected=%0d", sdaDrvLow, drvPrev);
        end
      end
      if (memWrEn) begin
        cChecks++;
        if (wrIdx >= expCnt || {memAddr, memWrData} != expWr[wrIdx]) begin
          cFails++;
          $display("FAIL R3/R2 write strobe: actual=%0h expected=%0h",
                   {memAddr, memWrData}, (wrIdx < expCnt) ? expWr[wrIdx] : 16'h0);
        end
        mem[memAddr] = memWrData;
        wrIdx++;
        sawWrite = 1'b1;
      end
      if (memRdEn) rdReg <= mem[memAddr];
      if (sclM && sdaBus && !sdaPrev && sawWrite) begin
        busyCnt = 300;
        sawWrite = 1'b0;
      end else if (busyCnt > 0) begin
        busyCnt--;
      end
    end
    drvPrev = sdaDrvLow;
    sdaPrev = sdaBus;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; wt(5); sclM = 1'b1; wt(5); sdaM = 1'b0; wt(5); sclM = 1'b0; wt(5);
  endtask

  task automatic busStop();
    sdaM = 1'b0; wt(5); sclM = 1'b1; wt(5); sdaM = 1'b1; wt(10);
  endtask

  task automatic putBit(input bit b);
    sdaM = b; wt(5); sclM = 1'b1; wt(10); sclM = 1'b0; wt(5);
  endtask

  task automatic getBit(output bit b);
    sdaM = 1'b1; wt(5); sclM = 1'b1; wt(5); b = sdaBus; wt(5); sclM = 1'b0; wt(5);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) putBit(b[i]);
    getBit(r);
    ack = !r;
  endtask

  task automatic recvByte(output logic [7:0] b, input bit ackIt);
    bit r;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      getBit(r);
      b = {b[6:0], r};
    end
    putBit(!ackIt);
  endtask

  task automatic doWrite(input logic [7:0] addr, input logic [7:0] d [8], input int n);
    bit a;
    busStart();
    sendByte(DEV_W, a); chk(a, "R1 device ack on write", a, 1);
    sendByte(addr, a);  chk(a, "R3 address byte ack", a, 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] ad;
      ad = addr + 8'(i);
      expWr[expCnt] = {ad, d[i]};
      expCnt++;
      expMem[ad] = d[i];
      sendByte(d[i], a); chk(a, "R3 data byte ack", a, 1);
    end
    modelPtr = addr + 8'(n);
    busStop();
    wt(400);
  endtask

  task automatic doRead(input logic [7:0] addr, input bit random, input int n, input string tag);
    bit a;
    logic [7:0] b;
    busStart();
    if (random) begin
      sendByte(DEV_W, a); chk(a, "R5 dummy write device ack", a, 1);
      sendByte(addr, a);  chk(a, "R5 dummy address ack", a, 1);
      modelPtr = addr;
      busStart();
    end
    sendByte(DEV_R, a); chk(a, "R1 device ack on read", a, 1);
    for (int i = 0; i < n; i++) begin
      recvByte(b, i < n - 1);
      chk(b == expMem[modelPtr], tag, b, expMem[modelPtr]);
      modelPtr = modelPtr + 8'd1;
    end
    chk(!sdaDrvLow, "R6 SDA released after master NACK", sdaDrvLow, 0);
    busStop();
    wt(20);
  endtask

  task automatic runAll();
    bit a;
    logic [7:0] b;
    // R10 reset state
    chk(!sdaDrvLow && !memWrEn && !memRdEn, "R10 reset state",
        {sdaDrvLow, memWrEn, memRdEn}, 0);

    // Byte write then immediate polling (R3, R7)
    busStart();
    sendByte(DEV_W, a); chk(a, "R1 device ack", a, 1);
    sendByte(8'h10, a); chk(a, "R3 address ack", a, 1);
    expWr[expCnt] = {8'h10, 8'hA5}; expCnt++; expMem[8'h10] = 8'hA5;
    sendByte(8'hA5, a); chk(a, "R3 data ack", a, 1);
    modelPtr = 8'h11;
    busStop();
    wt(5);
    busStart();
    sendByte(DEV_W, a); chk(!a, "R7 no ack while busy", a, 0);
    busStop();
    wt(400);
    busStart();
    sendByte(DEV_W, a); chk(a, "R7 ack after busy ends", a, 1);
    busStop();
    wt(20);

    // Page write and reads (R3, R5, R6, R4)
    doWrite(8'h20, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h0, 8'h0, 8'h0}, 5);
    doRead(8'h20, 1'b1, 4, "R5 R6 random sequential read data");
    doRead(8'h00, 1'b0, 1, "R4 current address read continues pointer");

    // Wrap across FFh (R4)
    doWrite(8'hFF, '{8'h9C, 8'h3E, 8'h61, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0}, 3);
    doRead(8'hFF, 1'b1, 2, "R4 read wraps FFh to 00h");
    doRead(8'h00, 1'b0, 1, "R4 pointer persists after wrap");

    // Foreign device bytes are ignored (R2)
    busStart();
    sendByte({4'b1010, 3'b001, 1'b0}, a); chk(!a, "R2 strap mismatch not acked", a, 0);
    sendByte(8'h10, a); chk(!a, "R2 later byte ignored", a, 0);
    sendByte(8'h77, a); chk(!a, "R2 later data ignored", a, 0);
    busStop();
    wt(20);
    busStart();
    sendByte({4'b1011, STRAP, 1'b1}, a); chk(!a, "R2 wrong code not acked", a, 0);
    recvByte(b, 1'b0); chk(b == 8'hFF, "R2 no data driven", b, 8'hFF);
    busStop();
    wt(20);
    doRead(8'h10, 1'b1, 1, "R2 location untouched by ignored bytes");

    // START in mid byte restarts reception (R9)
    busStart();
    putBit(1'b1); putBit(1'b0); putBit(1'b1); putBit(1'b0);
    doWrite(8'h30, '{8'hC3, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0}, 1);
    doRead(8'h30, 1'b1, 1, "R9 write after aborted byte");
    chk(wrIdx == expCnt, "R3 all writes seen", wrIdx, expCnt);
  endtask

  initial begin
    wt(5);
    rstN = 1'b1;
    wt(5);
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired: actual=1 expected=0");
    end
    $display("[TB] %0d tests run, %0d failed", nChecks + cChecks, nFails + cFails);
    $finish;
  end
endmodule